// File: doc/BRIEF.md
# External Data Memory Access Controller

This block sits between a CPU core and the data-memory space reached by move-external instructions. It takes single read or write requests with a 16-bit address and sends each one either to a 1 KB internal data RAM or to an external bus. The external bus has separate address and data lines and active-low read and write strobes. Every duration is counted in machine-cycle pulses, which arrive as a one-clock enable from outside the block.

The internal RAM covers the lowest 1 KB of the space, but only while its enable bit is set. Internal accesses always take two machine cycles. An external access has one address-setup machine cycle and then a strobe phase of stretch+1 machine cycles, so it lasts 2 to 9 machine cycles in total. When wait sampling is enabled, a wait input held high freezes the strobe phase. A one-clock done pulse tells the core that the access has finished. Read data is presented on the same cycle as that pulse.

The enable bit, the 3-bit stretch value and the wait-sampling enable sit in a small configuration register. That register is loaded from the core through a write strobe.

Top module: `xmem_ctrl`

## Requirements
- R1: After reset the internal RAM is disabled and the stretch value is 1. Both strobes are high, done_o is low, the write-data drive enable is low and rdata_o is 00h.
- R2: While the internal RAM is disabled, every address 0000h to FFFFh, including 0000h to 03FFh, goes to the external bus.
- R3: While the internal RAM is enabled, an access to 0000h to 03FFh uses the internal RAM. It asserts neither strobe and drives ext_addr_o as 0000h. A read returns the byte last written to that address.
- R4: An address of 0400h or above goes to the external bus even while the internal RAM is enabled.
- R5: An internal access finishes on the 2nd machine-cycle pulse after the request is accepted, whatever the stretch value.
- R6: An external access presents the address for one machine cycle. It then asserts a strobe for stretch+1 machine cycles and finishes on pulse stretch+2, giving 2 to 9 machine cycles.
- R7: A read asserts only ext_rd_no and a write asserts only ext_wr_no. The two strobes are never low together.
- R8: Write data is driven (ext_data_oe_o high, ext_data_o equal to the write byte) only while ext_wr_no is low. At all other times ext_data_o is 00h.
- R9: External read data is sampled from ext_data_i on the last clock of the strobe, at the finishing pulse, and appears on rdata_o together with done_o.
- R10: With wait sampling enabled, a machine-cycle pulse seen during the strobe while ext_wait_i is high does not advance the access. With wait sampling disabled, ext_wait_i has no effect.
- R11: done_o is a one-clock pulse, once per accepted request. A request made while an access is in progress is ignored.
- R12: The configuration bits change only on a clock with cfg_we_i high. A change takes effect for the following clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mc_en_i | input | 1 | Machine-cycle pulse, one clock wide |
| cfg_we_i | input | 1 | Load the configuration bits |
| cfg_iram_en_i | input | 1 | Internal RAM enable value |
| cfg_stretch_i | input | 3 | Stretch value |
| cfg_wait_en_i | input | 1 | Wait sampling enable value |
| req_i | input | 1 | Access request, accepted when idle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | Access address |
| wdata_i | input | 8 | Write byte |
| rdata_o | output | 8 | Read byte, valid with done_o |
| done_o | output | 1 | Access finished pulse |
| ext_addr_o | output | 16 | External address, 0 when no external access |
| ext_data_i | input | 8 | External read data |
| ext_data_o | output | 8 | External write data |
| ext_data_oe_o | output | 1 | External write data drive enable |
| ext_rd_no | output | 1 | External read strobe, active low |
| ext_wr_no | output | 1 | External write strobe, active low |
| ext_wait_i | input | 1 | Wait request, active high |

## Verification
The hardest situation to reach is a wait that lands inside the strobe phase with wait sampling enabled. A wait held before or after the strobe phase changes nothing, so the stimulus has to line it up with that phase. The bench waits for the strobe to fall, holds ext_wait_i high across several machine-cycle pulses and then releases it. A behavioural model counts only the pulses that were not blocked. The same wait pattern is repeated with sampling disabled to show that the input is ignored then. A second request issued in the middle of a long stretched access checks that a busy controller drops it.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_INT,
    ST_SETUP,
    ST_STROBE
  } xmem_state_e;
endpackage

// File: rtl/xmem_cfg.sv
module xmem_cfg #(
  parameter int STRETCH_W     = 3,
  parameter int STRETCH_RESET = 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic                 iram_en_i,
  input  logic [STRETCH_W-1:0] stretch_i,
  input  logic                 wait_en_i,
  output logic                 iram_en_o,
  output logic [STRETCH_W-1:0] stretch_o,
  output logic                 wait_en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iram_en_o <= 1'b0;
      stretch_o <= STRETCH_W'(STRETCH_RESET);
      wait_en_o <= 1'b0;
    end else if (we_i) begin
      iram_en_o <= iram_en_i;
      stretch_o <= stretch_i;
      wait_en_o <= wait_en_i;
    end
  end

  a_r12_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(iram_en_o) && $stable(stretch_o) && $stable(wait_en_o)));
endmodule

// File: rtl/xmem_iram.sv
module xmem_iram #(
  parameter int DEPTH  = 1024,
  parameter int DATA_W = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/xmem_seq.sv
module xmem_seq
  import xmem_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int STRETCH_W  = 3,
  parameter int IRAM_DEPTH = 1024
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 mc_en_i,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic                 iram_en_i,
  input  logic [STRETCH_W-1:0] stretch_i,
  input  logic                 wait_en_i,
  input  logic                 ext_wait_i,
  output logic                 finish_o,
  output logic                 int_sel_o,
  output logic                 we_o,
  output logic [ADDR_W-1:0]    addr_o,
  output logic [DATA_W-1:0]    wdata_o,
  output logic                 ext_active_o,
  output logic                 ext_rd_no,
  output logic                 ext_wr_no,
  output logic                 ext_oe_o
);
  xmem_state_e          state_q, state_d;
  logic [STRETCH_W-1:0] cnt_q, cnt_d;
  logic                 hold, hit_int;

  assign hit_int = iram_en_i && (addr_i < ADDR_W'(IRAM_DEPTH));
  assign hold    = wait_en_i && ext_wait_i;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    finish_o = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_i) begin
        state_d = hit_int ? ST_INT : ST_SETUP;
        cnt_d   = '0;
      end
      ST_INT: if (mc_en_i) begin
        if (cnt_q == STRETCH_W'(1)) begin
          finish_o = 1'b1;
          state_d  = ST_IDLE;
        end else cnt_d = cnt_q + 1'b1;
      end
      ST_SETUP: if (mc_en_i) state_d = ST_STROBE;
      ST_STROBE: if (mc_en_i && !hold) begin
        if (cnt_q == stretch_i) begin
          finish_o = 1'b1;
          state_d  = ST_IDLE;
        end else cnt_d = cnt_q + 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      int_sel_o <= 1'b0;
      we_o      <= 1'b0;
      addr_o    <= '0;
      wdata_o   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (state_q == ST_IDLE && req_i) begin
        int_sel_o <= hit_int;
        we_o      <= we_i;
        addr_o    <= addr_i;
        wdata_o   <= wdata_i;
      end
    end
  end

  assign ext_active_o = (state_q == ST_SETUP) || (state_q == ST_STROBE);
  assign ext_rd_no    = !(state_q == ST_STROBE && !we_o);
  assign ext_wr_no    = !(state_q == ST_STROBE && we_o);
  assign ext_oe_o     = (state_q == ST_STROBE) && we_o;

  a_r7_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_rd_no || ext_wr_no);
  a_r8_drive_with_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_oe_o |-> !ext_wr_no);
  a_r3_int_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_INT) |-> (ext_rd_no && ext_wr_no && !ext_active_o));
  a_r6_strobe_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STROBE && !mc_en_i) |=> (state_q == ST_STROBE && $stable(cnt_q)));
  a_r10_wait_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STROBE && mc_en_i && wait_en_i && ext_wait_i) |=>
      (state_q == ST_STROBE && $stable(cnt_q)));
  a_r11_busy_ignores: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> $stable(addr_o));
endmodule

// File: rtl/xmem_ctrl.sv
module xmem_ctrl #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int STRETCH_W  = 3,
  parameter int IRAM_DEPTH = 1024,
  localparam int IRAM_AW   = $clog2(IRAM_DEPTH)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 mc_en_i,
  input  logic                 cfg_we_i,
  input  logic                 cfg_iram_en_i,
  input  logic [STRETCH_W-1:0] cfg_stretch_i,
  input  logic                 cfg_wait_en_i,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic                 done_o,
  output logic [ADDR_W-1:0]    ext_addr_o,
  input  logic [DATA_W-1:0]    ext_data_i,
  output logic [DATA_W-1:0]    ext_data_o,
  output logic                 ext_data_oe_o,
  output logic                 ext_rd_no,
  output logic                 ext_wr_no,
  input  logic                 ext_wait_i
);
  logic                 iram_en, wait_en, finish, int_sel, acc_we, ext_active;
  logic [STRETCH_W-1:0] stretch;
  logic [ADDR_W-1:0]    acc_addr;
  logic [DATA_W-1:0]    acc_wdata, iram_rdata;

  xmem_cfg #(.STRETCH_W(STRETCH_W), .STRETCH_RESET(1)) u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .iram_en_i(cfg_iram_en_i), .stretch_i(cfg_stretch_i),
    .wait_en_i(cfg_wait_en_i),
    .iram_en_o(iram_en), .stretch_o(stretch), .wait_en_o(wait_en)
  );

  xmem_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STRETCH_W(STRETCH_W), .IRAM_DEPTH(IRAM_DEPTH)
  ) u_seq (
    .clk_i, .rst_ni, .mc_en_i, .req_i, .we_i, .addr_i, .wdata_i,
    .iram_en_i(iram_en), .stretch_i(stretch), .wait_en_i(wait_en), .ext_wait_i,
    .finish_o(finish), .int_sel_o(int_sel), .we_o(acc_we), .addr_o(acc_addr),
    .wdata_o(acc_wdata), .ext_active_o(ext_active),
    .ext_rd_no, .ext_wr_no, .ext_oe_o(ext_data_oe_o)
  );

  xmem_iram #(.DEPTH(IRAM_DEPTH), .DATA_W(DATA_W)) u_iram (
    .clk_i,
    .we_i(finish && int_sel && acc_we),
    .addr_i(acc_addr[IRAM_AW-1:0]),
    .wdata_i(acc_wdata),
    .rdata_o(iram_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o  <= 1'b0;
      rdata_o <= '0;
    end else begin
      done_o <= finish;
      if (finish && !acc_we) rdata_o <= int_sel ? iram_rdata : ext_data_i;
    end
  end

  assign ext_addr_o = ext_active ? acc_addr : '0;
  assign ext_data_o = ext_data_oe_o ? acc_wdata : '0;

  a_r11_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r9_rdata_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |=> (done_o || $stable(rdata_o)));
endmodule

// File: tb/xmem_ctrl_test.sv
module xmem_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mc_en = 1'b0;
  logic       cfg_we = 1'b0, cfg_iram_en = 1'b0, cfg_wait_en = 1'b0;
  logic [2:0] cfg_stretch = 3'd1;
  logic       req = 1'b0, we = 1'b0, ext_wait = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata, ext_dout, ext_din;
  logic        done, oe, rd_n, wr_n;
  logic [15:0] ext_addr;

  int checks = 0, fails = 0, cycles = 0, mc_k = 0;

  always #10 clk = ~clk;

  function automatic logic [7:0] ext_val(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  assign ext_din = ext_val(ext_addr);

  xmem_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .mc_en_i(mc_en),
    .cfg_we_i(cfg_we), .cfg_iram_en_i(cfg_iram_en), .cfg_stretch_i(cfg_stretch),
    .cfg_wait_en_i(cfg_wait_en), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .done_o(done), .ext_addr_o(ext_addr),
    .ext_data_i(ext_din), .ext_data_o(ext_dout), .ext_data_oe_o(oe),
    .ext_rd_no(rd_n), .ext_wr_no(wr_n), .ext_wait_i(ext_wait)
  );

  // machine-cycle pulses with an irregular spacing
  always @(negedge clk) begin
    mc_k++;
    mc_en <= (mc_k % 3 == 0) || (mc_k % 7 == 0);
  end

  // behavioural reference
  int          m_phase;  // 0 idle, 1 internal, 2 external
  int          m_p;
  bit          m_en, m_wen, m_we, m_int, m_done;
  int          m_str;
  logic [15:0] m_addr;
  logic [7:0]  m_wd, m_rdata;
  logic [7:0]  ref_mem [int];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_p = 0; m_en = 0; m_wen = 0; m_str = 1;
      m_done = 0; m_rdata = 8'h00; m_we = 0; m_int = 0; m_addr = '0; m_wd = '0;
    end else begin
      bit fin;
      fin = 0;
      m_done = 0;
      if (m_phase == 0) begin
        if (req) begin
          m_int  = m_en && (int'(addr) < 1024);
          m_addr = addr; m_we = we; m_wd = wdata; m_p = 0;
          m_phase = m_int ? 1 : 2;
        end
      end else if (mc_en) begin
        if (m_phase == 1) begin
          m_p++;
          if (m_p == 2) fin = 1;
        end else if (!(m_p >= 1 && m_wen && ext_wait)) begin
          m_p++;
          if (m_p == m_str + 2) fin = 1;
        end
      end
      if (fin) begin
        m_done = 1;
        if (m_int) begin
          if (m_we) ref_mem[int'(m_addr)] = m_wd;
          else m_rdata = ref_mem[int'(m_addr)];
        end else if (!m_we) m_rdata = ext_val(m_addr);
        m_phase = 0;
      end
      if (cfg_we) begin
        m_en = cfg_iram_en; m_wen = cfg_wait_en; m_str = int'(cfg_stretch);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      bit strb;
      strb = (m_phase == 2) && (m_p >= 1);
      chk("R7 rd strobe", rd_n, !(strb && !m_we));
      chk("R7 wr strobe", wr_n, !(strb && m_we));
      chk("R8 data drive", oe, strb && m_we);
      chk("R8 data value", ext_dout, (strb && m_we) ? m_wd : 8'h00);
      chk("R11 done", done, m_done);
      chk("R9 rdata", rdata, m_rdata);
      chk("R6 ext addr", ext_addr, (m_phase == 2) ? m_addr : 16'h0);
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected below 100000", cycles);
      finish_run();
    end
  end

  task automatic set_cfg(input bit en, input int str, input bit wen);
    @(negedge clk);
    cfg_we = 1; cfg_iram_en = en; cfg_stretch = 3'(str); cfg_wait_en = wen;
    @(negedge clk);
    cfg_we = 0;
  endtask

  // issues one access, returns the machine-cycle pulses it took
  task automatic access(input bit w, input logic [15:0] a, input logic [7:0] d,
                        output int n);
    @(negedge clk);
    req = 1; we = w; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    req = 0;
    n = 0;
    forever begin
      @(posedge clk);
      if (mc_en) n++;
      @(negedge clk);
      if (done) break;
    end
  endtask

  initial begin
    int n;
    bit saw_rd;
    int dones;
    repeat (3) @(negedge clk);
    chk("R1 rd_n in reset", rd_n, 1);
    rst_n = 1;
    @(negedge clk);
    chk("R1 rd_n", rd_n, 1);
    chk("R1 wr_n", wr_n, 1);
    chk("R1 done", done, 0);
    chk("R1 oe", oe, 0);
    chk("R1 rdata", rdata, 0);

    // R1/R2: default stretch 1, internal RAM off
    access(0, 16'h0123, 8'h00, n);
    chk("R2 low addr goes external, R6 stretch1 pulses", n, 3);
    chk("R9 ext read data", rdata, ext_val(16'h0123));
    access(1, 16'h0200, 8'hA5, n);
    chk("R6 ext write pulses", n, 3);

    set_cfg(1, 0, 0);
    access(0, 16'h8000, 8'h00, n);
    chk("R4 high addr external, R6 stretch0", n, 2);
    access(1, 16'h03FF, 8'h77, n);
    chk("R5 internal write pulses", n, 2);
    saw_rd = 0;
    fork
      access(0, 16'h03FF, 8'h00, n);
      repeat (40) begin @(negedge clk); if (!rd_n || !wr_n) saw_rd = 1; end
    join
    chk("R5 internal read pulses", n, 2);
    chk("R3 internal read data", rdata, 8'h77);
    chk("R3 no strobe on internal", saw_rd, 0);
    access(1, 16'h0000, 8'h1E, n);
    access(0, 16'h0000, 8'h00, n);
    chk("R3 internal read addr 0", rdata, 8'h1E);

    set_cfg(1, 7, 0);
    access(0, 16'h03FF, 8'h00, n);
    chk("R5 internal ignores stretch 7", n, 2);
    access(0, 16'h0400, 8'h00, n);
    chk("R4 0400h external, R6 stretch7 pulses", n, 9);
    chk("R9 read data 0400h", rdata, ext_val(16'h0400));

    set_cfg(0, 3, 0);
    access(0, 16'h03FF, 8'h00, n);
    chk("R2 disabled RAM goes external", rdata, ext_val(16'h03FF));
    chk("R6 stretch3 pulses", n, 5);

    // R10 wait ignored when sampling off
    fork
      access(1, 16'h1234, 8'h5B, n);
      begin
        @(negedge rd_n or negedge wr_n);
        ext_wait = 1; repeat (12) @(negedge clk); ext_wait = 0;
      end
    join
    chk("R10 wait ignored when disabled", n, 5);

    // R10 wait honoured when sampling on
    set_cfg(0, 2, 1);
    fork
      access(0, 16'h4321, 8'h00, n);
      begin
        @(negedge rd_n);
        ext_wait = 1; repeat (12) @(negedge clk); ext_wait = 0;
      end
    join
    chk("R10 wait extends access", n > 4, 1);
    chk("R10 read data after wait", rdata, ext_val(16'h4321));

    // R11 second request while busy is dropped
    set_cfg(0, 6, 0);
    dones = 0;
    fork
      access(0, 16'h2222, 8'h00, n);
      begin
        repeat (6) @(negedge clk);
        req = 1; addr = 16'h3333; @(negedge clk); req = 0;
      end
      repeat (60) begin @(negedge clk); if (done) dones++; end
    join
    chk("R11 busy request ignored", rdata, ext_val(16'h2222));
    chk("R11 one done pulse", dones, 1);

    // R12 mixed traffic, config changes between accesses
    for (int i = 0; i < 12; i++) begin
      set_cfg(i[0], i % 8, 0);
      access(i[1], 16'(i * 16'h0157), 8'(i * 13), n);
      chk("R12 pulses follow new stretch",
          n, ((i[0] == 1) && (i * 16'h0157 < 1024)) ? 2 : (i % 8) + 2);
    end
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule